// File: doc/BRIEF.md
# Key Matrix Scanner with Two-Sample Debounce

This block scans a switch matrix of up to eight rows by ten columns and turns key activity into press and release events. While nothing is pressed it sits in a quiet state. In that state it holds every enabled column low and watches the rows, which are pulled high outside the block. A low level on any enabled row wakes it up. From then on, each scan-period tick starts one scan cycle. In a scan cycle the block drives one column at a time and samples the rows.

Every key keeps two bits of history: the last raw sample and the debounced state. A key changes its debounced state only when two scans in a row agree. Each change is reported as an 8-bit event word: bit 7 is the direction and bits 6:0 are the key number. Events found in one scan come out one per clock, in column-major order. The host side would normally feed these words into an event queue. Once every key has been seen released, the scanner goes back to the quiet state.

Top module: `kp_scan_top`

## Requirements
- R1: After reset, and whenever the scanner is quiet, `col_drive` equals `col_en` (a 1 means that column is driven low) and `evt_valid` is 0.
- R2: The scanner leaves the quiet state only when an enabled row reads low, and its first scan starts on the clock after the next `scan_tick`.
- R3: During a scan at most one column is driven. The columns are visited in ascending index, one per clock, when no events are pending.
- R4: A press event is issued only on the second of two consecutive scans that both see the key closed.
- R5: While a key stays closed after its press event, later scans issue no further events for it.
- R6: A release event is issued only on the second of two consecutive scans that both see a pressed key open.
- R7: The key number in bits 6:0 is row × NUM_COLS + column + 1. With the default size this gives 1 to 80, for example row 2, column 3 gives 24.
- R8: Bit 7 of the event is 1 for a press and 0 for a release.
- R9: Events found in one scan are issued in column-major order, lowest row first within a column. Each event has a one-cycle `evt_valid` strobe, and events of the same column come on consecutive clocks.
- R10: The scanner returns to the quiet state once no key is debounced-pressed and no key holds a closed raw sample. A key seen closed on only one scan produces no event.
- R11: A row whose `row_en` bit is 0, or a column whose `col_en` bit is 0, neither wakes the scanner nor produces events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| row_in | input | NUM_ROWS | Row levels, high when open (pulled up) |
| row_en | input | NUM_ROWS | Rows that belong to the matrix |
| col_en | input | NUM_COLS | Columns that belong to the matrix |
| scan_tick | input | 1 | One-cycle pulse per scan period |
| col_drive | output | NUM_COLS | 1 = drive that column low |
| evt_valid | output | 1 | Event strobe |
| evt_data | output | 8 | {press flag, 7-bit key number} |

## Verification
The bench builds the block with its default size of 8 rows and 10 columns. This puts the extreme key numbers 1 and 80 in reach. It also allows several keys sharing one column, so both the column-major ordering and the back-to-back strobes can be seen. The bench models the matrix as closures that pull a row low when their column is driven. Its tick gap is long enough for a full scan that emits events.

// File: rtl/kp_pkg.sv
package kp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_WAIT   = 3'd1,
        ST_SAMPLE = 3'd2,
        ST_EMIT   = 3'd3,
        ST_DONE   = 3'd4
    } kp_state_e;

    localparam int EVT_W  = 8;
    localparam int CODE_W = 7;

endpackage

// File: rtl/kp_col_sel.sv
module kp_col_sel #(
    parameter int NUM_COLS = 10,
    parameter int CIDX_W   = 4
) (
    input  logic                all_drive,
    input  logic                one_drive,
    input  logic [CIDX_W-1:0]   col_idx,
    input  logic [NUM_COLS-1:0] col_en,
    output logic [NUM_COLS-1:0] col_drive
);

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_col
        assign col_drive[c] = col_en[c] &
                              (all_drive | (one_drive & (col_idx == CIDX_W'(c))));
    end

endmodule

// File: rtl/kp_evt_pick.sv
module kp_evt_pick #(
    parameter int NUM_ROWS = 8,
    parameter int RIDX_W   = 3
) (
    input  logic [NUM_ROWS-1:0] pend,
    output logic                found,
    output logic [RIDX_W-1:0]   idx,
    output logic [NUM_ROWS-1:0] pick_oh
);

    always_comb begin
        found   = 1'b0;
        idx     = '0;
        pick_oh = '0;
        for (int r = NUM_ROWS - 1; r >= 0; r--) begin
            if (pend[r]) begin
                found   = 1'b1;
                idx     = RIDX_W'(r);
                pick_oh = '0;
                pick_oh[r] = 1'b1;
            end
        end
    end

endmodule

// File: rtl/kp_key_track.sv
module kp_key_track #(
    parameter int NUM_ROWS = 8,
    parameter int NUM_COLS = 10,
    parameter int CIDX_W   = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                upd,
    input  logic [CIDX_W-1:0]   col_idx,
    input  logic [NUM_ROWS-1:0] raw,
    output logic [NUM_ROWS-1:0] press_vec,
    output logic [NUM_ROWS-1:0] rel_vec,
    output logic                any_active
);

    logic [NUM_COLS-1:0][NUM_ROWS-1:0] prev_q, prev_d;
    logic [NUM_COLS-1:0][NUM_ROWS-1:0] stab_q, stab_d;
    logic [NUM_ROWS-1:0] cur_prev, cur_stab;

    always_comb begin
        cur_prev = '0;
        cur_stab = '0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (col_idx == CIDX_W'(c)) begin
                cur_prev = prev_q[c];
                cur_stab = stab_q[c];
            end
        end
        // two agreeing samples flip the debounced state
        press_vec  = raw & cur_prev & ~cur_stab;
        rel_vec    = ~raw & ~cur_prev & cur_stab;
        any_active = (|prev_q) | (|stab_q);

        prev_d = prev_q;
        stab_d = stab_q;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (upd && (col_idx == CIDX_W'(c))) begin
                prev_d[c] = raw;
                stab_d[c] = (cur_stab | press_vec) & ~rel_vec;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '0;
            stab_q <= '0;
        end else begin
            prev_q <= prev_d;
            stab_q <= stab_d;
        end
    end

    for (genvar c = 0; c < NUM_COLS; c++) begin : g_ac
        for (genvar r = 0; r < NUM_ROWS; r++) begin : g_ar
            AST_PRESS_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(stab_q[c][r]) |-> $past(prev_q[c][r])); // R4
            AST_RELEASE_TWO_SAMPLES: assert property (@(posedge clk) disable iff (!rst_n)
                $fell(stab_q[c][r]) |-> !$past(prev_q[c][r])); // R6
        end
    end

endmodule

// File: rtl/kp_scan_top.sv
module kp_scan_top
    import kp_pkg::*;
#(
    parameter int NUM_ROWS = 8,
    parameter int NUM_COLS = 10
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_ROWS-1:0] row_in,
    input  logic [NUM_ROWS-1:0] row_en,
    input  logic [NUM_COLS-1:0] col_en,
    input  logic                scan_tick,
    output logic [NUM_COLS-1:0] col_drive,
    output logic                evt_valid,
    output logic [EVT_W-1:0]    evt_data
);

    localparam int CIDX_W   = (NUM_COLS > 1) ? $clog2(NUM_COLS) : 1;
    localparam int RIDX_W   = (NUM_ROWS > 1) ? $clog2(NUM_ROWS) : 1;
    localparam int NUM_KEYS = NUM_ROWS * NUM_COLS;
    localparam logic [CIDX_W-1:0] LAST_COL = CIDX_W'(NUM_COLS - 1);

    typedef struct packed {
        kp_state_e             st;
        logic [CIDX_W-1:0]     col;
        logic [NUM_ROWS-1:0]   pend_press;
        logic [NUM_ROWS-1:0]   pend_rel;
        logic                  ev_v;
        logic [EVT_W-1:0]      ev_d;
    } scan_regs_t;

    scan_regs_t r_q, r_d;

    logic                col_on;
    logic [NUM_ROWS-1:0] raw;
    logic                wake;
    logic                upd;
    logic [NUM_ROWS-1:0] press_vec, rel_vec;
    logic                any_active;
    logic                pick_found;
    logic [RIDX_W-1:0]   pick_idx;
    logic [NUM_ROWS-1:0] pick_oh;
    logic [NUM_ROWS-1:0] pend_all, pend_rest;
    logic                pick_press;
    logic [CODE_W-1:0]   pick_code;
    logic                all_drive, one_drive;

    always_comb begin
        col_on = 1'b0;
        for (int c = 0; c < NUM_COLS; c++) begin
            if (r_q.col == CIDX_W'(c)) col_on = col_en[c];
        end
    end

    assign raw       = ~row_in & row_en & {NUM_ROWS{col_on}};
    assign wake      = |(~row_in & row_en);
    assign upd       = (r_q.st == ST_SAMPLE);
    assign all_drive = (r_q.st == ST_IDLE) || (r_q.st == ST_WAIT);
    assign one_drive = (r_q.st == ST_SAMPLE) || (r_q.st == ST_EMIT);
    assign pend_all  = r_q.pend_press | r_q.pend_rel;
    assign pend_rest = pend_all & ~pick_oh;
    assign pick_press = |(r_q.pend_press & pick_oh);

    always_comb begin
        int code_i;
        code_i    = int'(pick_idx) * NUM_COLS + int'(r_q.col) + 1;
        pick_code = CODE_W'(code_i);
    end

    kp_col_sel #(.NUM_COLS(NUM_COLS), .CIDX_W(CIDX_W)) u_col_sel (
        .all_drive (all_drive),
        .one_drive (one_drive),
        .col_idx   (r_q.col),
        .col_en    (col_en),
        .col_drive (col_drive)
    );

    kp_key_track #(.NUM_ROWS(NUM_ROWS), .NUM_COLS(NUM_COLS), .CIDX_W(CIDX_W)) u_track (
        .clk        (clk),
        .rst_n      (rst_n),
        .upd        (upd),
        .col_idx    (r_q.col),
        .raw        (raw),
        .press_vec  (press_vec),
        .rel_vec    (rel_vec),
        .any_active (any_active)
    );

    kp_evt_pick #(.NUM_ROWS(NUM_ROWS), .RIDX_W(RIDX_W)) u_pick (
        .pend    (pend_all),
        .found   (pick_found),
        .idx     (pick_idx),
        .pick_oh (pick_oh)
    );

    always_comb begin
        r_d      = r_q;
        r_d.ev_v = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (wake) r_d.st = ST_WAIT;
            end
            ST_WAIT: begin
                if (scan_tick) begin
                    r_d.st  = ST_SAMPLE;
                    r_d.col = '0;
                end
            end
            ST_SAMPLE: begin
                r_d.pend_press = press_vec;
                r_d.pend_rel   = rel_vec;
                if (|(press_vec | rel_vec)) begin
                    r_d.st = ST_EMIT;
                end else if (r_q.col == LAST_COL) begin
                    r_d.st = ST_DONE;
                end else begin
                    r_d.col = r_q.col + 1'b1;
                end
            end
            ST_EMIT: begin
                if (pick_found) begin
                    r_d.ev_v = 1'b1;
                    r_d.ev_d = {pick_press, pick_code};
                end
                r_d.pend_press = r_q.pend_press & ~pick_oh;
                r_d.pend_rel   = r_q.pend_rel & ~pick_oh;
                if (pend_rest == '0) begin
                    if (r_q.col == LAST_COL) begin
                        r_d.st = ST_DONE;
                    end else begin
                        r_d.st  = ST_SAMPLE;
                        r_d.col = r_q.col + 1'b1;
                    end
                end
            end
            ST_DONE: begin
                r_d.st = any_active ? ST_WAIT : ST_IDLE;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign evt_valid = r_q.ev_v;
    assign evt_data  = r_q.ev_d;

    AST_WAKE_NEEDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_WAIT && $past(r_q.st) == ST_IDLE) |-> $past(wake)); // R2
    AST_SCAN_STARTS_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SAMPLE && $past(r_q.st) == ST_WAIT) |-> $past(scan_tick)); // R2
    AST_ONE_COLUMN: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_SAMPLE) |-> $onehot0(col_drive)); // R3
    AST_CODE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_valid |-> (evt_data[6:0] != '0 && int'(evt_data[6:0]) <= NUM_KEYS)); // R7
    AST_QUIET_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.st == ST_IDLE) |-> !evt_valid); // R1

endmodule

// File: tb/kp_scan_top_tb.sv
module kp_scan_top_tb;

    localparam int NR  = 8;
    localparam int NC  = 10;
    localparam int GAP = 150;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NR-1:0] row_in;
    logic [NR-1:0] row_en = '1;
    logic [NC-1:0] col_en = '1;
    logic          scan_tick = 1'b0;
    logic [NC-1:0] col_drive;
    logic          evt_valid;
    logic [7:0]    evt_data;

    logic [NR-1:0][NC-1:0] key_dn = '0;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;
    int ev_n = 0;
    logic [7:0] ev_d [64];
    int         ev_c [64];
    bit done = 1'b0;

    always #2 clk = ~clk;

    kp_scan_top #(.NUM_ROWS(NR), .NUM_COLS(NC)) u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .row_in    (row_in),
        .row_en    (row_en),
        .col_en    (col_en),
        .scan_tick (scan_tick),
        .col_drive (col_drive),
        .evt_valid (evt_valid),
        .evt_data  (evt_data)
    );

    always_comb begin
        for (int r = 0; r < NR; r++) row_in[r] = ~|(key_dn[r] & col_drive);
    end

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (rst_n && evt_valid && ev_n < 64) begin
            ev_d[ev_n] = evt_data;
            ev_c[ev_n] = cyc;
            ev_n = ev_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic chk_ev(input int i, input logic [7:0] exp, input string req);
        chk(ev_n > i && ev_d[i] == exp, req, (ev_n > i) ? int'(ev_d[i]) : -1, int'(exp));
    endtask

    task automatic do_tick();
        @(negedge clk) scan_tick = 1'b1;
        @(negedge clk) scan_tick = 1'b0;
        repeat (GAP) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        chk(col_drive == col_en, "R1 quiet drive", int'(col_drive), int'(col_en));
        chk(ev_n == 0 && !evt_valid, "R1 no event", ev_n, 0);
    endtask

    task automatic t_single();
        int bad;
        ev_n = 0;
        key_dn[2][3] = 1'b1;
        repeat (4) @(negedge clk);
        chk(ev_n == 0, "R2 no event before tick", ev_n, 0);
        // first scan: watch column walk
        scan_tick = 1'b1;
        bad = 0;
        for (int k = 0; k < NC; k++) begin
            @(negedge clk);
            scan_tick = 1'b0;
            if (col_drive != NC'(1 << k)) bad++;
        end
        chk(bad == 0, "R3 column walk", bad, 0);
        repeat (GAP) @(negedge clk);
        chk(ev_n == 0, "R4 one sample no press", ev_n, 0);
        do_tick();
        chk(ev_n == 1, "R4 press count", ev_n, 1);
        chk_ev(0, 8'h98, "R7 R8 press code row2 col3");
        repeat (3) do_tick();
        chk(ev_n == 1, "R5 held no repeat", ev_n, 1);
        key_dn[2][3] = 1'b0;
        do_tick();
        chk(ev_n == 1, "R6 one open sample no release", ev_n, 1);
        do_tick();
        chk_ev(1, 8'h18, "R6 R8 release code");
        chk(col_drive == col_en, "R10 back to quiet", int'(col_drive), int'(col_en));
    endtask

    task automatic t_glitch();
        ev_n = 0;
        key_dn[4][7] = 1'b1;
        repeat (3) @(negedge clk);
        do_tick();
        key_dn[4][7] = 1'b0;
        do_tick();
        chk(ev_n == 0, "R10 glitch no event", ev_n, 0);
        chk(col_drive == col_en, "R10 glitch quiet", int'(col_drive), int'(col_en));
    endtask

    task automatic t_corners();
        ev_n = 0;
        key_dn[0][0] = 1'b1;
        key_dn[7][9] = 1'b1;
        repeat (3) @(negedge clk);
        do_tick();
        do_tick();
        chk_ev(0, 8'h81, "R7 key 1 press");
        chk_ev(1, 8'hD0, "R7 key 80 press");
        key_dn = '0;
        do_tick();
        do_tick();
        chk_ev(2, 8'h01, "R7 key 1 release");
        chk_ev(3, 8'h50, "R7 key 80 release");
    endtask

    task automatic t_multi();
        ev_n = 0;
        key_dn[5][1] = 1'b1;
        key_dn[2][1] = 1'b1;
        key_dn[0][4] = 1'b1;
        repeat (3) @(negedge clk);
        do_tick();
        do_tick();
        chk(ev_n == 3, "R9 count", ev_n, 3);
        chk_ev(0, 8'h96, "R9 first col1 row2");
        chk_ev(1, 8'hB4, "R9 second col1 row5");
        chk_ev(2, 8'h85, "R9 third col4 row0");
        chk(ev_n >= 2 && ev_c[1] - ev_c[0] == 1, "R9 back to back",
            (ev_n >= 2) ? ev_c[1] - ev_c[0] : -1, 1);
        key_dn = '0;
        do_tick();
        do_tick();
        chk_ev(3, 8'h16, "R9 R8 release order 1");
        chk_ev(4, 8'h34, "R9 release order 2");
        chk_ev(5, 8'h05, "R9 release order 3");
        chk(col_drive == col_en, "R10 quiet after multi", int'(col_drive), int'(col_en));
    endtask

    task automatic t_disabled();
        ev_n = 0;
        @(negedge clk);
        row_en = 8'hF7;
        col_en = 10'h3BF;
        key_dn[3][0] = 1'b1;
        repeat (5) @(negedge clk);
        chk(col_drive == col_en, "R11 disabled row no wake", int'(col_drive), int'(col_en));
        do_tick();
        do_tick();
        chk(ev_n == 0, "R11 disabled row no event", ev_n, 0);
        key_dn[3][0] = 1'b0;
        key_dn[1][6] = 1'b1;
        repeat (5) @(negedge clk);
        chk(col_drive == col_en, "R11 disabled col no wake", int'(col_drive), int'(col_en));
        do_tick();
        do_tick();
        chk(ev_n == 0, "R11 disabled col no event", ev_n, 0);
        key_dn[1][6] = 1'b0;
        key_dn[1][5] = 1'b1;
        repeat (3) @(negedge clk);
        do_tick();
        do_tick();
        chk_ev(0, 8'h90, "R11 enabled key still works");
        key_dn = '0;
        do_tick();
        do_tick();
        chk_ev(1, 8'h10, "R11 enabled key release");
        row_en = '1;
        col_en = '1;
    endtask

    initial begin
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_single();
        t_glitch();
        t_corners();
        t_multi();
        t_disabled();
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual 0x%0h expected 0x%0h", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule